// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into a stream of column addresses, one per clock. A request carries a starting column, a length code and an ordering choice. The block steps through the beats of the burst and raises a valid flag for each beat. It marks the final beat with a last flag.

The order of the beats stays inside the aligned group of columns that holds the starting column. The group is 2, 4 or 8 columns wide. In sequential order the low bits count up and wrap. In interleaved order the low bits are the start bits XORed with the beat number. The columns above the group do not change during a burst.

A burst can end before its full length in two ways. A stop request ends it at the beat on which the stop is seen. A new start request abandons it, and the new burst begins on the next cycle. The block is meant to sit in a memory controller's column path, next to the logic that moves the data.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `beat_valid` and `beat_last` are low.
- R2: `blen_code` selects the burst length: 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. A `start` seen at a rising edge with one of these codes makes beat 0 appear in the following cycle, showing `start_col`. After that, one beat appears per cycle until all the beats have been shown.
- R3: During a burst, every column bit above the low log2(length) bits equals the same bit of the start column.
- R4: With `interleave` = 0, the low log2(length) bits of beat i are (start low bits + i) modulo the length. For example, length 8 from 5 gives the order 5,6,7,0,1,2,3,4.
- R5: With `interleave` = 1, the low log2(length) bits of beat i are the start low bits XOR i. For example, length 8 from 5 gives the order 5,4,7,6,1,0,3,2.
- R6: `beat_last` is high on beat length−1. `beat_valid` is low in the next cycle, unless a new start was accepted.
- R7: `stop` held high in a cycle with a valid beat makes that beat the last one: `beat_last` is high and `beat_valid` is low in the next cycle. `stop` has no effect while no burst is running.
- R8: `start` in a cycle with a valid beat marks that beat as last, and beat 0 of the new burst appears in the next cycle.
- R9: A `start` with any other `blen_code` (reserved) produces no beats. It also ends any burst that is running.
- R10: The length, ordering and start column are captured when `start` is accepted. Changes to `blen_code`, `interleave` or `start_col` during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst (restarts any running burst) |
| start_col | input | COL_W | First column of the burst |
| blen_code | input | 3 | Burst length selection |
| interleave | input | 1 | 0 = sequential order, 1 = XOR order |
| stop | input | 1 | End the running burst at the current beat |
| col_out | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is present |
| beat_last | output | 1 | Current beat ends its burst |

## Verification
The final beat of a burst can coincide with a new `start`, and a `stop` can coincide with the first beat. In both cases two end conditions fall on the same beat. The bench provokes this by raising `start` exactly on the cycle where the final or cut beat shows, and by raising `stop` on beat 0. A scoreboard then expects exactly one beat flagged last, followed directly by beat 0 of the new burst or by silence. A reserved-code start issued during a running burst is judged the same way: the current beat must end it, and no further beats may appear.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       blen_code,
  input  logic             interleave,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             beat_valid,
  output logic             beat_last
);
  localparam int GW = 3;

  logic             active;
  logic [COL_W-1:0] base;
  logic [GW-1:0]    idx;
  logic [GW-1:0]    msk;
  logic             ilv;

  logic             code_ok;
  logic [GW-1:0]    new_msk;
  logic [GW-1:0]    off;
  logic             at_end;

  always_comb begin
    case (blen_code)
      3'b001:  new_msk = 3'b001;
      3'b010:  new_msk = 3'b011;
      3'b011:  new_msk = 3'b111;
      default: new_msk = 3'b000;
    endcase
  end

  assign code_ok    = (blen_code == 3'b001) || (blen_code == 3'b010) || (blen_code == 3'b011);
  assign off        = ilv ? (base[GW-1:0] ^ idx) : (base[GW-1:0] + idx);
  assign col_out    = {base[COL_W-1:GW], (off & msk) | (base[GW-1:0] & ~msk)};
  assign at_end     = (idx == msk) || stop || start;
  assign beat_valid = active;
  assign beat_last  = active && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      idx    <= '0;
      msk    <= '0;
      ilv    <= 1'b0;
    end else if (start) begin
      active <= code_ok;
      base   <= start_col;
      idx    <= '0;
      msk    <= new_msk;
      ilv    <= interleave;
    end else if (active) begin
      if (at_end) active <= 1'b0;
      else        idx    <= idx + 1'b1;
    end
  end

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && code_ok |=> beat_valid && col_out == $past(start_col));

  assert_upper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> beat_valid && col_out[COL_W-1:GW] == $past(col_out[COL_W-1:GW]));

  assert_end_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last && !start |=> !beat_valid);

  assert_stop_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && stop |-> beat_last);

  assert_restart_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && start |-> beat_last);

  assert_reserved_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !code_ok |=> !beat_valid);

  assert_ends_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> beat_valid);
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [9:0] start_col = '0;
  logic [2:0] blen_code = '0;
  logic       interleave = 1'b0;
  logic       stop = 1'b0;
  logic [9:0] col_out;
  logic       beat_valid;
  logic       beat_last;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [10:0] q[$];
  string       tq[$];

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .blen_code(blen_code), .interleave(interleave), .stop(stop),
    .col_out(col_out), .beat_valid(beat_valid), .beat_last(beat_last)
  );

  function automatic int blen(input logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [9:0] exp_col(input logic [9:0] c, input int bl, input int i, input bit ilv);
    logic [2:0] m, o;
    m = 3'(bl - 1);
    o = ilv ? (c[2:0] ^ 3'(i)) : (c[2:0] + 3'(i));
    return {c[9:3], (o & m) | (c[2:0] & ~m)};
  endfunction

  task automatic burst(input logic [9:0] c, input logic [2:0] code, input bit ilv,
                       input int cut, input bit chain, input string tag);
    int bl, n;
    bl = blen(code);
    start = 1'b1; start_col = c; blen_code = code; interleave = ilv;
    n = (cut < bl) ? cut + 1 : bl;
    for (int i = 0; i < n; i++) q.push_back({(i == n - 1) ? 1'b1 : 1'b0, exp_col(c, bl, i, ilv)});
    for (int i = 0; i < n; i++) tq.push_back(tag);
    @(posedge clk) #1;
    start = 1'b0; start_col = ~c; blen_code = 3'b011 ^ code; interleave = ~ilv;
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) begin
        if (chain) return;
        if (cut < bl) stop = 1'b1;
      end
      @(posedge clk) #1;
      stop = 1'b0;
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(posedge clk) #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && beat_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R9/R7: unexpected beat col=%h last=%b, expected no beat", col_out, beat_last);
      end else begin
        logic [10:0] e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        if ({beat_last, col_out} !== e) begin
          fails++;
          $display("FAIL %s: got last=%b col=%h, expected last=%b col=%h", t, beat_last, col_out, e[10], e[9:0]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog: run hung, got %0d cycles, expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (beat_valid !== 1'b0 || beat_last !== 1'b0) begin
      fails++;
      $display("FAIL R1: valid=%b last=%b, expected 0 0", beat_valid, beat_last);
    end
    @(posedge clk) #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (beat_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: valid=%b after release, expected 0", beat_valid);
    end
    @(posedge clk) #1;
    burst(10'h0D5, 3'b011, 1'b0, 99, 1'b0, "R4 seq8 from 5");
    idle(2);
    burst(10'h125, 3'b011, 1'b1, 99, 1'b0, "R5 ilv8 from 5");
    idle(1);
    burst(10'h006, 3'b010, 1'b0, 99, 1'b0, "R2 R3 seq4 from 6");
    burst(10'h3F3, 3'b001, 1'b1, 99, 1'b0, "R2 R6 ilv2 from 3");
    burst(10'h201, 3'b010, 1'b1, 99, 1'b0, "R10 ilv4 from 1");
    idle(1);
    burst(10'h0A2, 3'b011, 1'b0, 2, 1'b0, "R7 stop at beat 2");
    stop = 1'b1;
    idle(3);
    stop = 1'b0;
    burst(10'h0F0, 3'b011, 1'b1, 0, 1'b0, "R7 stop on beat 0");
    idle(1);
    burst(10'h157, 3'b011, 1'b0, 3, 1'b1, "R8 restart cut");
    burst(10'h2C6, 3'b010, 1'b1, 99, 1'b0, "R8 new burst");
    burst(10'h011, 3'b001, 1'b0, 99, 1'b1, "R8 start on final beat");
    burst(10'h08E, 3'b001, 1'b0, 99, 1'b0, "R8 follow-on");
    burst(10'h033, 3'b000, 1'b0, 99, 1'b0, "R9 code 0");
    burst(10'h033, 3'b111, 1'b1, 99, 1'b0, "R9 code 7");
    idle(2);
    burst(10'h1B4, 3'b011, 1'b0, 1, 1'b1, "R9 reserved ends burst");
    burst(10'h000, 3'b100, 1'b0, 99, 1'b0, "R9 reserved restart");
    idle(4);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d beats missing, expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule